// File: doc/BRIEF.md
# Program Memory Cache Controller

This block manages an on-chip instruction RAM. The RAM serves the CPU in one of two ways: as program SRAM at the bottom of the fetch address space, or as a direct-mapped instruction cache in front of a slower external memory. A three-bit mode field in a control and status register chooses the behaviour. The CPU fetch port returns one word per request. The external read port supplies words on a miss, and in mapped mode it also serves fetches outside the internal range. A stall output holds the CPU while the controller is busy.

Software has no direct invalidate command. The cache is cleared only when the mode field goes from a non-cache value to the cache value. That write starts a sweep that clears one tag per clock, and the CPU stays stalled until every line has been cleared. After the sweep, code that was cached must be fetched again from external memory.

A fetch is presented by holding `fetch_req_i` for one cycle while `stall_o` is low and no register write is presented. The result arrives as a single-cycle pulse on `fetch_valid_o`. A register write is taken in a cycle where `stall_o` is low. Reads of the register are combinational.

Top module: `pmc_top`

## Requirements
- R1: After reset, `reg_rdata_o` is 0, so the mode field at bits 7:5 holds 000b (mapped). `stall_o`, `fetch_valid_o` and `ext_req_o` are all low.
- R2: Only bits 15:0 of the register can be written, and they read back exactly as written. Bits 31:16 always read 0, whatever value is written to them.
- R3: In mapped mode (mode 000b), a fetch whose address has all bits above bit 5 at zero reads RAM word `addr[5:0]`. With the defaults, cache index addr[5:2] and word offset addr[1:0] map onto that same RAM word. The result is valid in the cycle after the request, with no external read.
- R4: In mapped mode, a fetch outside the internal range makes exactly one external read of that address and returns its data. It leaves the RAM unchanged, so a later internal fetch of the same low address bits returns the old word.
- R5: In cache mode (mode 010b), a miss raises `stall_o` and reads the whole 4-word line from external memory at ascending addresses from the line base. It then writes the tag with valid set and returns the requested word after the stall drops.
- R6: In cache mode, a hit returns the cached word in the cycle after the request, with no stall and no external read.
- R7: A write that moves the mode field from a non-cache value to 010b stalls the CPU for exactly 16 cycles (one per line), starting the cycle after the write. Every tag is invalid afterwards, so an address that hit before misses again.
- R8: Writing 010b while already in cache mode, or writing 000b from cache mode, causes no stall. The tags are kept, so a cached address still hits after a 010b-to-010b write.
- R9: Reserved mode values (anything other than 000b and 010b, for example 100b) behave as mapped mode. A write from a reserved value to 010b starts the invalidation sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_i | input | 1 | Instruction fetch request, one cycle |
| fetch_addr_i | input | 16 | Fetch word address |
| fetch_valid_o | output | 1 | Fetch result valid pulse |
| fetch_data_o | output | 32 | Fetched instruction word |
| stall_o | output | 1 | CPU stall |
| ext_req_o | output | 1 | External read request, held until served |
| ext_addr_o | output | 16 | External read word address |
| ext_valid_i | input | 1 | External read data valid |
| ext_data_i | input | 32 | External read data |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 32 | Control register write data |
| reg_rdata_o | output | 32 | Control register read value |

## Verification
A local fetch is a hit in cache mode, or an internal address in mapped or reserved mode. Its result is due in the cycle after the request is presented. The bench records the cycle at which each request is presented and requires a latency of exactly one for local fetches. For a miss or an external mapped fetch it requires a latency above one, together with an exact count of external reads: four for a line fill, one for a mapped external fetch and none for a local fetch. After each register write, the stall is counted from the following cycle, and it must last exactly 16 cycles for a transition into cache mode and zero cycles for every other write.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int unsigned MODE_LSB = 5;
  localparam int unsigned MODE_W   = 3;
  localparam logic [MODE_W-1:0] MODE_MAPPED = 3'b000;
  localparam logic [MODE_W-1:0] MODE_CACHE  = 3'b010;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_EXT,
    ST_SWEEP
  } pmc_state_e;
endpackage

// File: rtl/pmc_csr.sv
module pmc_csr
  import pmc_pkg::*;
#(
  parameter int unsigned REG_W = 32,
  parameter int unsigned WR_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             cache_en_o,
  output logic             sweep_o
);
  logic [WR_W-1:0]   csr_q;
  logic [MODE_W-1:0] mode_cur, mode_new;

  assign mode_cur   = csr_q[MODE_LSB +: MODE_W];
  assign mode_new   = wdata_i[MODE_LSB +: MODE_W];
  assign cache_en_o = (mode_cur == MODE_CACHE);
  // entry into cache mode from mapped or reserved triggers invalidation
  assign sweep_o    = we_i && (mode_new == MODE_CACHE) && !cache_en_o;
  assign rdata_o    = {{(REG_W-WR_W){1'b0}}, csr_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) csr_q <= '0;
    else if (we_i) csr_q <= wdata_i[WR_W-1:0];
  end

  p_wr_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rdata_o[WR_W-1:0] == $past(wdata_i[WR_W-1:0]));

  p_upper_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && $past(1'b1) && (wdata_i[REG_W-1:WR_W] != '0)) |=>
      rdata_o[REG_W-1:WR_W] != $past(wdata_i[REG_W-1:WR_W]));

  p_sweep_enters_cache_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sweep_o |=> cache_en_o);
endmodule

// File: rtl/pmc_tags.sv
module pmc_tags #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned TAG_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             hit_o,
  input  logic             set_i,
  input  logic [IDX_W-1:0] set_idx_i,
  input  logic [TAG_W-1:0] set_tag_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] clr_idx_i
);
  localparam int unsigned LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] valid_q;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) valid_q[g] <= 1'b0;
      else if (clr_i && clr_idx_i == IDX_W'(g)) valid_q[g] <= 1'b0;
      else if (set_i && set_idx_i == IDX_W'(g)) valid_q[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (set_i) tag_q[set_idx_i] <= set_tag_i;
  end

  assign hit_o = valid_q[lk_idx_i] && (tag_q[lk_idx_i] == lk_tag_i);

  p_clr_line_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !valid_q[$past(clr_idx_i)]);

  p_set_line_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> valid_q[$past(set_idx_i)]);
endmodule

// File: rtl/pmc_ram.sv
module pmc_ram #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned WORDS = 1 << AW;

  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned OFF_W  = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cache_en_i,
  input  logic                   sweep_i,
  input  logic                   fetch_go_i,
  input  logic [ADDR_W-1:0]      fetch_addr_i,
  input  logic                   hit_i,
  input  logic                   ext_valid_i,
  input  logic [DATA_W-1:0]      ext_data_i,
  output logic                   stall_o,
  output logic                   ext_req_o,
  output logic [ADDR_W-1:0]      ext_addr_o,
  output logic                   ram_we_o,
  output logic [IDX_W+OFF_W-1:0] ram_waddr_o,
  output logic                   ram_re_o,
  output logic                   set_o,
  output logic [IDX_W-1:0]       set_idx_o,
  output logic [ADDR_W-IDX_W-OFF_W-1:0] set_tag_o,
  output logic                   clr_o,
  output logic [IDX_W-1:0]       clr_idx_o,
  output logic                   rsp_valid_o,
  output logic                   rsp_ram_o,
  output logic [DATA_W-1:0]      hold_data_o
);
  localparam int unsigned RAM_AW = IDX_W + OFF_W;
  localparam logic [IDX_W-1:0] LINE_LAST = IDX_W'((1 << IDX_W) - 1);
  localparam logic [OFF_W-1:0] WORD_LAST = OFF_W'((1 << OFF_W) - 1);

  pmc_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  line_cnt_q;
  logic [OFF_W-1:0]  word_cnt_q;
  logic              idle, accept, is_int, local_hit;

  assign idle      = (state_q == ST_IDLE);
  assign stall_o   = !idle;
  assign accept    = idle && fetch_go_i && !sweep_i;
  assign is_int    = (fetch_addr_i[ADDR_W-1:RAM_AW] == '0);
  // reserved modes fall through to mapped behaviour
  assign local_hit = cache_en_i ? hit_i : is_int;
  assign ram_re_o  = accept && local_hit;

  assign ext_req_o   = (state_q == ST_FILL) || (state_q == ST_EXT);
  assign ext_addr_o  = (state_q == ST_FILL) ? {addr_q[ADDR_W-1:OFF_W], word_cnt_q} : addr_q;
  assign ram_we_o    = (state_q == ST_FILL) && ext_valid_i;
  assign ram_waddr_o = {addr_q[RAM_AW-1:OFF_W], word_cnt_q};
  assign set_o       = ram_we_o && (word_cnt_q == WORD_LAST);
  assign set_idx_o   = addr_q[RAM_AW-1:OFF_W];
  assign set_tag_o   = addr_q[ADDR_W-1:RAM_AW];
  assign clr_o       = (state_q == ST_SWEEP);
  assign clr_idx_o   = line_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      line_cnt_q  <= '0;
      word_cnt_q  <= '0;
      rsp_valid_o <= 1'b0;
      rsp_ram_o   <= 1'b0;
      hold_data_o <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (sweep_i) begin
            state_q    <= ST_SWEEP;
            line_cnt_q <= '0;
          end else if (accept) begin
            addr_q <= fetch_addr_i;
            if (local_hit) begin
              rsp_valid_o <= 1'b1;
              rsp_ram_o   <= 1'b1;
            end else if (cache_en_i) begin
              state_q    <= ST_FILL;
              word_cnt_q <= '0;
            end else begin
              state_q <= ST_EXT;
            end
          end
        end
        ST_FILL: begin
          if (ext_valid_i) begin
            if (word_cnt_q == addr_q[OFF_W-1:0]) hold_data_o <= ext_data_i;
            word_cnt_q <= word_cnt_q + 1'b1;
            if (word_cnt_q == WORD_LAST) begin
              state_q     <= ST_IDLE;
              rsp_valid_o <= 1'b1;
              rsp_ram_o   <= 1'b0;
            end
          end
        end
        ST_EXT: begin
          if (ext_valid_i) begin
            hold_data_o <= ext_data_i;
            state_q     <= ST_IDLE;
            rsp_valid_o <= 1'b1;
            rsp_ram_o   <= 1'b0;
          end
        end
        ST_SWEEP: begin
          line_cnt_q <= line_cnt_q + 1'b1;
          if (line_cnt_q == LINE_LAST) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_sweep_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sweep_i && idle) |=> (state_q == ST_SWEEP) && (line_cnt_q == '0));

  p_sweep_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_o && line_cnt_q != LINE_LAST) |=> clr_o && stall_o);

  p_sweep_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_o && line_cnt_q == LINE_LAST) |=> !stall_o);

  p_no_ext_in_sweep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |-> !ext_req_o);

  p_hit_fast_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cache_en_i && hit_i) |=> rsp_valid_o && rsp_ram_o && !stall_o);

  p_local_no_ext_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_re_o |=> !ext_req_o);

  p_fill_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_o |=> rsp_valid_o && !stall_o);

  p_ext_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_EXT) && ext_valid_i) |=> !ext_req_o && rsp_valid_o);
endmodule

// File: rtl/pmc_top.sv
module pmc_top #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LINE_WORDS = 4,
  parameter int unsigned NUM_LINES  = 16,
  parameter int unsigned REG_W      = 32,
  parameter int unsigned WR_W       = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic              fetch_valid_o,
  output logic [DATA_W-1:0] fetch_data_o,
  output logic              stall_o,
  output logic              ext_req_o,
  output logic [ADDR_W-1:0] ext_addr_o,
  input  logic              ext_valid_i,
  input  logic [DATA_W-1:0] ext_data_i,
  input  logic              reg_we_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o
);
  localparam int unsigned OFF_W  = $clog2(LINE_WORDS);
  localparam int unsigned IDX_W  = $clog2(NUM_LINES);
  localparam int unsigned RAM_AW = OFF_W + IDX_W;
  localparam int unsigned TAG_W  = ADDR_W - RAM_AW;

  logic              cache_en, sweep, hit, csr_we;
  logic              ram_we, ram_re, set, clr, rsp_ram;
  logic [RAM_AW-1:0] ram_waddr;
  logic [IDX_W-1:0]  set_idx, clr_idx;
  logic [TAG_W-1:0]  set_tag;
  logic [DATA_W-1:0] ram_rdata, hold_data;

  assign csr_we = reg_we_i && !stall_o;

  pmc_csr #(.REG_W(REG_W), .WR_W(WR_W)) u_csr (
    .clk_i, .rst_ni,
    .we_i       (csr_we),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .cache_en_o (cache_en),
    .sweep_o    (sweep)
  );

  pmc_tags #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk_i, .rst_ni,
    .lk_idx_i  (fetch_addr_i[RAM_AW-1:OFF_W]),
    .lk_tag_i  (fetch_addr_i[ADDR_W-1:RAM_AW]),
    .hit_o     (hit),
    .set_i     (set),
    .set_idx_i (set_idx),
    .set_tag_i (set_tag),
    .clr_i     (clr),
    .clr_idx_i (clr_idx)
  );

  pmc_ram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
    .clk_i, .rst_ni,
    .we_i    (ram_we),
    .waddr_i (ram_waddr),
    .wdata_i (ext_data_i),
    .re_i    (ram_re),
    .raddr_i (fetch_addr_i[RAM_AW-1:0]),
    .rdata_o (ram_rdata)
  );

  pmc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_ctrl (
    .clk_i, .rst_ni,
    .cache_en_i   (cache_en),
    .sweep_i      (sweep),
    .fetch_go_i   (fetch_req_i && !reg_we_i),
    .fetch_addr_i (fetch_addr_i),
    .hit_i        (hit),
    .ext_valid_i  (ext_valid_i),
    .ext_data_i   (ext_data_i),
    .stall_o      (stall_o),
    .ext_req_o    (ext_req_o),
    .ext_addr_o   (ext_addr_o),
    .ram_we_o     (ram_we),
    .ram_waddr_o  (ram_waddr),
    .ram_re_o     (ram_re),
    .set_o        (set),
    .set_idx_o    (set_idx),
    .set_tag_o    (set_tag),
    .clr_o        (clr),
    .clr_idx_o    (clr_idx),
    .rsp_valid_o  (fetch_valid_o),
    .rsp_ram_o    (rsp_ram),
    .hold_data_o  (hold_data)
  );

  assign fetch_data_o = rsp_ram ? ram_rdata : hold_data;

  p_rst_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !stall_o && !fetch_valid_o);
endmodule

// File: tb/pmc_top_bench.sv
module pmc_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LINES      = 16;
  localparam int LWORDS     = 4;

  logic        clk, rst_n;
  logic        fetch_req, fetch_valid, stall, ext_req, ext_valid, reg_we;
  logic [15:0] fetch_addr, ext_addr;
  logic [31:0] fetch_data, ext_data, reg_wdata, reg_rdata;

  pmc_top u_pmc_top (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_req_i(fetch_req), .fetch_addr_i(fetch_addr),
    .fetch_valid_o(fetch_valid), .fetch_data_o(fetch_data),
    .stall_o(stall),
    .ext_req_o(ext_req), .ext_addr_o(ext_addr),
    .ext_valid_i(ext_valid), .ext_data_i(ext_data),
    .reg_we_i(reg_we), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata)
  );

  int checks = 0, fails = 0, cyc = 0, ext_cnt = 0, resp_cnt = 0;

  logic [31:0] q_data[$];
  int          q_ext[$];
  bit          q_fast[$];
  int          q_cyc[$];
  string       q_tag[$];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] ext_word(input logic [15:0] a);
    return {(~a) ^ 16'h5a5a, a};
  endfunction

  // external memory: answers one cycle after each request, then idles a cycle
  always @(posedge clk) begin
    if (!rst_n) begin
      ext_valid <= 1'b0;
      ext_data  <= '0;
    end else begin
      ext_valid <= ext_req && !ext_valid;
      if (ext_req && !ext_valid) begin
        ext_data <= ext_word(ext_addr);
        ext_cnt  <= ext_cnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pops the expected item when a result appears
  always @(negedge clk) begin
    if (rst_n && fetch_valid) begin
      if (q_data.size() == 0) begin
        check(1'b0, "R5", "unexpected result", fetch_data, 32'h0);
      end else begin
        logic [31:0] ed;
        int ee, ec, lat;
        bit ef;
        string et;
        ed = q_data.pop_front(); ee = q_ext.pop_front(); ef = q_fast.pop_front();
        ec = q_cyc.pop_front(); et = q_tag.pop_front();
        lat = cyc - ec;
        check(fetch_data == ed, et, "data", fetch_data, ed);
        if (ef) check(lat == 1, et, "latency", lat, 1);
        else    check(lat > 1, et, "slow latency", lat, 2);
        check(ext_cnt == ee, et, "ext reads", ext_cnt, ee);
      end
      resp_cnt++;
    end
  end

  task automatic fetch(input logic [15:0] a, input logic [31:0] exp, input bit fast,
                       input int ext_delta, input string tag);
    int n0;
    @(negedge clk);
    while (stall) @(negedge clk);
    q_data.push_back(exp); q_ext.push_back(ext_cnt + ext_delta);
    q_fast.push_back(fast); q_cyc.push_back(cyc); q_tag.push_back(tag);
    n0 = resp_cnt;
    fetch_req = 1'b1; fetch_addr = a;
    @(negedge clk);
    fetch_req = 1'b0;
    while (resp_cnt == n0) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d, input int exp_stall, input string tag);
    int n;
    @(negedge clk);
    while (stall) @(negedge clk);
    reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    n = 0;
    while (stall) begin n++; @(negedge clk); end
    check(n == exp_stall, tag, "stall cycles", n, exp_stall);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; fetch_req = 1'b0; fetch_addr = '0; reg_we = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reg_rdata == 32'h0, "R1", "reg after reset", reg_rdata, 32'h0);
    check(!stall && !fetch_valid && !ext_req, "R1", "idle outputs",
          {29'h0, stall, fetch_valid, ext_req}, 32'h0);

    // R2 low bits writable, mode bits 7:5 = 000b so no sweep
    wr(32'hABCD_1F03, 0, "R2");
    check(reg_rdata == 32'h0000_1F03, "R2", "readback", reg_rdata, 32'h0000_1F03);

    // R7 mapped -> cache sweeps every line
    wr(32'h0000_0040, LINES, "R7");

    // R5 miss fills line, R6 hits
    fetch(16'h0100, ext_word(16'h0100), 1'b0, LWORDS, "R5");
    fetch(16'h0102, ext_word(16'h0102), 1'b1, 0, "R6");
    fetch(16'h0103, ext_word(16'h0103), 1'b1, 0, "R6");
    fetch(16'h0233, ext_word(16'h0233), 1'b0, LWORDS, "R5");
    fetch(16'h0500, ext_word(16'h0500), 1'b0, LWORDS, "R5");
    fetch(16'h0101, ext_word(16'h0101), 1'b0, LWORDS, "R5");
    fetch(16'h0231, ext_word(16'h0231), 1'b1, 0, "R6");

    // R8 rewrite of cache mode keeps tags
    wr(32'h0000_0040, 0, "R8");
    fetch(16'h0100, ext_word(16'h0100), 1'b1, 0, "R8");

    // R8 leaving cache mode, no stall; R3 mapped internal reads RAM
    wr(32'h0000_0000, 0, "R8");
    fetch(16'h0001, ext_word(16'h0101), 1'b1, 0, "R3");
    fetch(16'h0033, ext_word(16'h0233), 1'b1, 0, "R3");

    // R4 mapped external, no allocation
    fetch(16'h0801, ext_word(16'h0801), 1'b0, 1, "R4");
    fetch(16'h0001, ext_word(16'h0101), 1'b1, 0, "R4");

    // R9 reserved mode 100b acts as mapped
    wr(32'h0000_0080, 0, "R9");
    fetch(16'h0002, ext_word(16'h0102), 1'b1, 0, "R9");
    fetch(16'h0C00, ext_word(16'h0C00), 1'b0, 1, "R9");

    // R9 reserved -> cache sweeps; R7 previously cached line misses
    wr(32'h0000_0040, LINES, "R9");
    fetch(16'h0100, ext_word(16'h0100), 1'b0, LWORDS, "R7");
    fetch(16'h0230, ext_word(16'h0230), 1'b0, LWORDS, "R7");

    // R2 upper bits ignored
    wr(32'hFFFF_0040, 0, "R2");
    check(reg_rdata == 32'h0000_0040, "R2", "upper ignored", reg_rdata, 32'h0000_0040);
    fetch(16'h0103, ext_word(16'h0103), 1'b1, 0, "R6");

    repeat (4) @(negedge clk);
    check(q_data.size() == 0, "R5", "pending results", q_data.size(), 0);
    summary();
    $finish;
  end
endmodule